// File: doc/BRIEF.md
# Quick DMA Channel Trigger Unit

This block watches the register bus of a DMA controller. It turns a software write into a specific word of a transfer descriptor into a transfer request. There are eight quick channels. Each channel is bound through its own map register to one descriptor slot and to one word within that slot. The descriptor memory sits elsewhere. The block only observes the writes that go to it.

When a write lands on the bound word of an enabled channel, that channel's event becomes pending. The pending channel with the lowest number is presented to the transfer engine on a valid/ready request port, together with its slot number. A trigger that arrives while the channel still has a pending event is not queued. It is recorded as a missed event instead. Software sets and clears the channel enables, clears pending events and clears missed events through write-one registers. Each of these registers also reads back the state it controls.

Top module: `qdt_trigger_unit`

## Requirements
- R1: After reset, every map register, the enable mask, the pending mask and the missed mask read zero, and `req_valid` is low.
- R2: The map register of channel c is at offset 0x200 + 4·c. It holds the slot number in bits 13:5 and the word index in bits 4:2. All other bits read zero.
- R3: A write to offset 0x4000 + 32·slot + 4·word sets the pending bit of every enabled channel whose map holds that slot and word. The bit is visible from the clock edge that takes the write.
- R4: A write leaves a channel's pending bit unchanged when the channel is disabled, when the channel's map register is zero (unbound), or when the write goes to another slot or another word.
- R5: A trigger on a channel whose event is already pending, and whose request is not accepted in that cycle, sets that channel's missed bit. The pending state stays a single event.
- R6: Writing offset 0x108C sets the enable bits written as 1. Writing offset 0x1088 clears the enable bits written as 1. Bits written as 0 change nothing. Reading 0x108C returns the enable mask.
- R7: While any event is pending, `req_valid` is high, `req_chan` names the lowest-numbered pending channel, and `req_slot` gives that channel's mapped slot. A cycle with `req_valid` and `req_ready` both high clears that channel's pending bit.
- R8: Writing 1s to offset 0x1094 clears those pending bits, and reading 0x1094 returns the pending mask. Writing 1s to offset 0x314 clears those missed bits, and reading 0x314 returns the missed mask.
- R9: Several channels bound to the same slot and word all become pending from a single write.
- R10: A trigger in the same cycle as the acceptance of that channel's request leaves the channel pending with a fresh event and does not set its missed bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register bus write strobe |
| wr_addr | input | 16 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 16 | Byte offset of the combinational read |
| rd_data | output | 32 | Read data for `rd_addr` |
| req_valid | output | 1 | A channel event is waiting for the engine |
| req_chan | output | 3 | Channel number of the presented event |
| req_slot | output | 9 | Descriptor slot bound to that channel |
| req_ready | input | 1 | Engine accepts the presented event |

## Verification
The hardest case to reach is a trigger that lands in the very cycle the engine accepts the same channel. The bus write and the ready strobe have to coincide on one clock edge. The bench drives both on the same negative edge once only that channel is pending. It then confirms that the channel stays pending and that its missed bit stays clear. The bench also sweeps all eight words of a bound slot, a neighbouring slot, and several pending patterns that it drains, predicting the service order from the lowest set bit.

// File: rtl/qdt_pkg.sv
package qdt_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 32;
  localparam int SLOT_W    = 9;
  localparam int WORD_W    = 3;
  localparam int MAP_W     = SLOT_W + WORD_W;
  localparam int MAP_LSB   = 2;
  localparam int SLOT_LSB  = 5;
  localparam int SLOT_SPAN = (1 << SLOT_W) << SLOT_LSB;

  localparam logic [ADDR_W-1:0] MAP_BASE  = 16'h0200;
  localparam logic [ADDR_W-1:0] SLOT_BASE = 16'h4000;
  localparam logic [ADDR_W-1:0] EN_SET    = 16'h108C;
  localparam logic [ADDR_W-1:0] EN_CLR    = 16'h1088;
  localparam logic [ADDR_W-1:0] PEND_CLR  = 16'h1094;
  localparam logic [ADDR_W-1:0] MISS_CLR  = 16'h0314;
endpackage

// File: rtl/qdt_map_regs.sv
module qdt_map_regs
  import qdt_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [MAP_W-1:0]          wr_map,
  output logic [NCH-1:0][MAP_W-1:0] map_q,
  output logic [NCH-1:0]            hit
);
  logic [NCH-1:0][MAP_W-1:0] map_d;
  logic [NCH-1:0]            map_we;
  logic                      in_win;
  logic [MAP_W-1:0]          wr_loc;

  assign in_win = wr_en && (32'(wr_addr) >= 32'(SLOT_BASE))
                        && (32'(wr_addr) <  32'(SLOT_BASE) + SLOT_SPAN);
  assign wr_loc = wr_addr[SLOT_LSB+SLOT_W-1:MAP_LSB];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign map_we[c] = wr_en && (wr_addr == MAP_BASE + ADDR_W'(4 * c));
    assign map_d[c]  = map_we[c] ? wr_map : map_q[c];
    assign hit[c]    = in_win && (map_q[c] != '0) && (map_q[c] == wr_loc);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         map_q[c] <= '0;
      else if (map_we[c]) map_q[c] <= map_d[c];
    end
  end
endmodule

// File: rtl/qdt_evt_state.sv
module qdt_evt_state
  import qdt_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [NCH-1:0]      wr_bits,
  input  logic [NCH-1:0]      hit,
  input  logic [NCH-1:0]      acc,
  output logic [NCH-1:0]      en_q,
  output logic [NCH-1:0]      pend_q,
  output logic [NCH-1:0]      miss_q
);
  logic [NCH-1:0] en_d, pend_d, miss_d;
  logic [NCH-1:0] en_set, en_clr, pend_clr, miss_clr, trig;

  assign en_set   = (wr_en && wr_addr == EN_SET)   ? wr_bits : '0;
  assign en_clr   = (wr_en && wr_addr == EN_CLR)   ? wr_bits : '0;
  assign pend_clr = (wr_en && wr_addr == PEND_CLR) ? wr_bits : '0;
  assign miss_clr = (wr_en && wr_addr == MISS_CLR) ? wr_bits : '0;
  assign trig     = hit & en_q;

  always_comb begin
    en_d   = (en_q | en_set) & ~en_clr;
    pend_d = (pend_q & ~acc & ~pend_clr) | trig;
    miss_d = (miss_q & ~miss_clr) | (trig & pend_q & ~acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      miss_q <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      miss_q <= miss_d;
    end
  end
endmodule

// File: rtl/qdt_prio.sv
module qdt_prio #(
  parameter int NCH  = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]  pend,
  output logic            valid,
  output logic [CH_W-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) begin
        valid = 1'b1;
        idx   = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/qdt_trigger_unit.sv
module qdt_trigger_unit
  import qdt_pkg::*;
#(
  parameter int NCH  = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              req_valid,
  output logic [CH_W-1:0]   req_chan,
  output logic [SLOT_W-1:0] req_slot,
  input  logic              req_ready
);
  logic [NCH-1:0][MAP_W-1:0] map_q;
  logic [NCH-1:0]            hit, acc, en_q, pend_q, miss_q;
  logic                      unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:SLOT_LSB+SLOT_W];

  qdt_map_regs #(.NCH(NCH)) map_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_map(wr_data[SLOT_LSB+SLOT_W-1:MAP_LSB]), .map_q(map_q), .hit(hit)
  );

  qdt_evt_state #(.NCH(NCH)) evt_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bits(wr_data[NCH-1:0]), .hit(hit), .acc(acc),
    .en_q(en_q), .pend_q(pend_q), .miss_q(miss_q)
  );

  qdt_prio #(.NCH(NCH)) prio_i (
    .pend(pend_q), .valid(req_valid), .idx(req_chan)
  );

  always_comb begin
    acc = '0;
    if (req_valid && req_ready) acc[req_chan] = 1'b1;
  end

  assign req_slot = map_q[req_chan][MAP_W-1:WORD_W];

  always_comb begin
    rd_data = '0;
    if (rd_addr == EN_SET)        rd_data[NCH-1:0] = en_q;
    else if (rd_addr == PEND_CLR) rd_data[NCH-1:0] = pend_q;
    else if (rd_addr == MISS_CLR) rd_data[NCH-1:0] = miss_q;
    else begin
      for (int c = 0; c < NCH; c++) begin
        if (rd_addr == MAP_BASE + ADDR_W'(4 * c))
          rd_data[SLOT_LSB+SLOT_W-1:MAP_LSB] = map_q[c];
      end
    end
  end
endmodule

// File: rtl/qdt_trigger_unit_chk.sv
module qdt_trigger_unit_chk #(
  parameter int NCH  = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            req_valid,
  input logic            req_ready,
  input logic [CH_W-1:0] req_chan,
  input logic [NCH-1:0]  en_q,
  input logic [NCH-1:0]  pend_q,
  input logic [NCH-1:0]  miss_q
);
  logic [NCH-1:0] below_m;
  always_comb begin
    for (int i = 0; i < NCH; i++) below_m[i] = (i < int'(req_chan));
  end

  // R7: presented channel is pending and no lower channel is
  a_r7_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (pend_q[req_chan] && ((pend_q & below_m) == '0)));

  // R7: an unaccepted request is held when the bus is idle
  a_r7_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !wr_en) |=> req_valid);

  // R5: a missed bit only rises on a channel that was already pending
  a_r5_miss_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((miss_q & ~$past(miss_q) & ~$past(pend_q)) == '0));

  // R4: a pending bit only rises on a channel that was enabled
  a_r4_no_event_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

  // R6: enables change only through a bus write
  a_r6_enable_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
endmodule

bind qdt_trigger_unit qdt_trigger_unit_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .req_valid(req_valid),
  .req_ready(req_ready), .req_chan(req_chan), .en_q(en_q),
  .pend_q(pend_q), .miss_q(miss_q)
);

// File: tb/qdt_trigger_unit_tb.sv
module qdt_trigger_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, wr_en, req_ready, req_valid;
  logic [15:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [2:0]  req_chan;
  logic [8:0]  req_slot;
  int          n_chk = 0;
  int          n_err = 0;
  logic [31:0] v;

  qdt_trigger_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .req_valid(req_valid), .req_chan(req_chan), .req_slot(req_slot),
    .req_ready(req_ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] trig_a(int slot, int word);
    return 16'(16'h4000 + slot * 32 + word * 4);
  endfunction
  function automatic logic [31:0] map_v(int slot, int word);
    return 32'((slot << 5) | (word << 2));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic accept;
    @(negedge clk); req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; req_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(16'h108C, v); chk("R1 enable", v, 0);
    rd(16'h1094, v); chk("R1 pending", v, 0);
    rd(16'h0314, v); chk("R1 missed", v, 0);
    chk("R1 req_valid", 32'(req_valid), 0);
    for (int c = 0; c < 8; c++) begin
      rd(16'(16'h0200 + 4 * c), v); chk("R1 map", v, 0);
    end

    // R2: map layout, all bits written, only slot/word fields kept
    for (int c = 0; c < 8; c++) begin
      wr(16'(16'h0200 + 4 * c), 32'hFFFF_FFFF);
      rd(16'(16'h0200 + 4 * c), v); chk("R2 field mask", v, 32'h0000_3FFC);
      wr(16'(16'h0200 + 4 * c), map_v(c * 61 + 7, 7 - c));
    end
    for (int c = 0; c < 8; c++) begin
      rd(16'(16'h0200 + 4 * c), v); chk("R2 readback", v, map_v(c * 61 + 7, 7 - c));
    end

    // R6: write-one set and clear of enables
    wr(16'h108C, 32'h0000_00A5); rd(16'h108C, v); chk("R6 set", v, 32'hA5);
    wr(16'h1088, 32'h0000_0005); rd(16'h108C, v); chk("R6 clear", v, 32'hA0);
    wr(16'h108C, 32'h0000_0000); rd(16'h108C, v); chk("R6 zero set", v, 32'hA0);
    wr(16'h1088, 32'h0000_0000); rd(16'h108C, v); chk("R6 zero clear", v, 32'hA0);
    wr(16'h1088, 32'h0000_00FF);

    // R3/R4: sweep every word of a bound slot and its neighbour
    wr(16'h020C, map_v(100, 5));
    wr(16'h108C, 32'h08);
    for (int w = 0; w < 8; w++) begin
      wr(trig_a(100, w), 32'h1234);
      rd(16'h1094, v);
      chk(w == 5 ? "R3 trigger word" : "R4 other word", v, w == 5 ? 32'h08 : 32'h0);
      wr(16'h1094, 32'h08);
      rd(16'h1094, v); chk("R8 pending clear", v, 0);
      wr(trig_a(101, w), 32'h1234);
      rd(16'h1094, v); chk("R4 other slot", v, 0);
    end

    // R4: disabled channel and unbound channel
    wr(16'h1088, 32'h08);
    wr(trig_a(100, 5), 32'h1);
    rd(16'h1094, v); chk("R4 disabled", v, 0);
    wr(16'h0200, 32'h0);
    wr(16'h108C, 32'h01);
    wr(16'h4000, 32'h1);
    rd(16'h1094, v); chk("R4 unbound", v, 0);
    chk("R4 no request", 32'(req_valid), 0);

    // R5/R8: double trigger records a miss
    wr(16'h1088, 32'hFF);
    wr(16'h108C, 32'h08);
    wr(trig_a(100, 5), 32'h1);
    rd(16'h0314, v); chk("R5 first no miss", v, 0);
    wr(trig_a(100, 5), 32'h1);
    rd(16'h1094, v); chk("R5 pending kept", v, 32'h08);
    rd(16'h0314, v); chk("R5 missed", v, 32'h08);
    wr(16'h0314, 32'h08);
    rd(16'h0314, v); chk("R8 missed clear", v, 0);
    rd(16'h1094, v); chk("R8 pending untouched", v, 32'h08);
    wr(16'h1094, 32'h08);

    // R7: priority drain over several patterns
    for (int c = 0; c < 8; c++) wr(16'(16'h0200 + 4 * c), map_v(10 + c, c));
    wr(16'h108C, 32'hFF);
    for (int k = 0; k < 6; k++) begin
      logic [7:0] p;
      case (k)
        0: p = 8'hFF; 1: p = 8'h5A; 2: p = 8'h81;
        3: p = 8'h30; 4: p = 8'h01; default: p = 8'h80;
      endcase
      for (int c = 7; c >= 0; c--) if (p[c]) wr(trig_a(10 + c, c), 32'h0);
      rd(16'h1094, v); chk("R3 pattern pending", v, 32'(p));
      while (p != 0) begin
        int lo;
        lo = 0;
        for (int c = 7; c >= 0; c--) if (p[c]) lo = c;
        chk("R7 valid", 32'(req_valid), 1);
        chk("R7 chan", 32'(req_chan), 32'(lo));
        chk("R7 slot", 32'(req_slot), 32'(10 + lo));
        accept();
        p[lo] = 1'b0;
        rd(16'h1094, v); chk("R7 accept clears", v, 32'(p));
      end
      chk("R7 idle", 32'(req_valid), 0);
    end
    rd(16'h0314, v); chk("R5 no spurious miss", v, 0);

    // R9: two channels on one word
    wr(16'h0204, map_v(200, 2));
    wr(16'h0218, map_v(200, 2));
    wr(trig_a(200, 2), 32'h0);
    rd(16'h1094, v); chk("R9 shared word", v, 32'h42);
    wr(16'h1094, 32'hFF);

    // R10: trigger coincides with acceptance of the same channel
    wr(16'h0200, map_v(300, 3));
    wr(trig_a(300, 3), 32'h0);
    chk("R10 presented", 32'(req_chan), 0);
    @(negedge clk);
    req_ready = 1'b1; wr_en = 1'b1; wr_addr = trig_a(300, 3); wr_data = 32'h0;
    @(negedge clk);
    req_ready = 1'b0; wr_en = 1'b0;
    rd(16'h1094, v); chk("R10 still pending", v, 32'h01);
    rd(16'h0314, v); chk("R10 no miss", v, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule